// File: doc/BRIEF.md
# Dual-Clock Bidirectional Port Mailbox Controller

This block sits between two independent 36-bit bidirectional ports and a FIFO core that lives outside it. Each port runs on its own clock and has four control inputs: an active-low chip select, a direction select, a transfer enable and a mailbox select. From these the block derives the output-drive enable of each port's bus, qualified FIFO write and FIFO read strobes, and accesses to two mailbox registers.

Mailbox 1 carries one word from port A to port B. Mailbox 2 carries one word from port B to port A. Each mailbox has an active-low full flag. The flag lives in the writer's clock domain. A write sets it to full. A read in the other domain returns it to empty by a toggle that crosses the clock boundary through a synchronizer. The FIFO storage is not part of the block. Port A's bus feeds the FIFO write data, and port B's bus shows the FIFO read data when the mailbox select is low.

Top module: `mbx_port_ctrl`

## Requirements
- R1: While a port's chip select is high (`a_csn_i`/`b_csn_i` = 1), that port's output enable is 0 and it raises no FIFO strobe, whatever its other inputs are.
- R2: With chip select low, port A drives its bus (`a_oe_o`=1) when `a_dir_i`=0 and takes input when `a_dir_i`=1. Port B uses the opposite encoding: it takes input when `b_dir_i`=0 and drives when `b_dir_i`=1.
- R3: `fifo_wr_o` is 1 exactly when port A is in input direction with enable 1 and mailbox select 0. `fifo_wdata_o` equals `a_data_i`.
- R4: `fifo_rd_o` is 1 exactly when port B is in output direction with enable 1 and mailbox select 0. While `b_mbx_i`=0, `b_data_o` equals `fifo_rdata_i`.
- R5: A rising `clk_a_i` edge with port A in input direction, enable 1, mailbox select 1 and `mbf1_no`=1 stores `a_data_i` in mailbox 1 and drives `mbf1_no` to 0 after that edge. While `b_mbx_i`=1, `b_data_o` shows mailbox 1.
- R6: A rising `clk_b_i` edge with port B in output direction, enable 1 and mailbox select 1 reads mailbox 1. If mailbox 1 holds an unread word, `mbf1_no` returns to 1 within 8 `clk_a_i` cycles. A read of an empty mailbox leaves the flag unaffected by any later write.
- R7: Mailbox 2 mirrors R5 and R6 with the roles swapped. Port B in input direction with enable 1 and mailbox select 1 writes it and drives `mbf2_no` to 0. A port A read in output direction with mailbox select 1 returns `mbf2_no` to 1 within 8 `clk_b_i` cycles. `a_data_o` shows mailbox 2.
- R8: With enable 0, no FIFO strobe is raised and no mailbox is written or read.
- R9: A mailbox write attempted while that mailbox's flag is 0 is ignored, and the stored word is kept.
- R10: Reset (`rst_ni`=0, asynchronous) sets `mbf1_no` and `mbf2_no` to 1 (empty).
- R11: Output enables and data-path selection follow chip select, direction and mailbox select combinationally, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Port A clock |
| clk_b_i | input | 1 | Port B clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| a_csn_i | input | 1 | Port A chip select, active low |
| a_dir_i | input | 1 | Port A direction, 1 = input (write) |
| a_en_i | input | 1 | Port A transfer enable |
| a_mbx_i | input | 1 | Port A mailbox select |
| a_data_i | input | 36 | Port A bus, pad input side |
| a_data_o | output | 36 | Port A bus, pad output side (mailbox 2) |
| a_oe_o | output | 1 | Port A output-drive enable |
| b_csn_i | input | 1 | Port B chip select, active low |
| b_dir_i | input | 1 | Port B direction, 0 = input (write) |
| b_en_i | input | 1 | Port B transfer enable |
| b_mbx_i | input | 1 | Port B mailbox select |
| b_data_i | input | 36 | Port B bus, pad input side |
| b_data_o | output | 36 | Port B bus, pad output side |
| b_oe_o | output | 1 | Port B output-drive enable |
| fifo_wr_o | output | 1 | FIFO write strobe, `clk_a_i` domain |
| fifo_wdata_o | output | 36 | FIFO write data |
| fifo_rd_o | output | 1 | FIFO read strobe, `clk_b_i` domain |
| fifo_rdata_i | input | 36 | FIFO read data |
| mbf1_no | output | 1 | Mailbox 1 full flag, active low, `clk_a_i` domain |
| mbf2_no | output | 1 | Mailbox 2 full flag, active low, `clk_b_i` domain |

## Verification
The assertions assume that each port's control inputs are stable around the rising edge of that port's own clock, and that the two clocks are unrelated. A flag's return to empty is therefore checked with a cycle bound, not an exact edge. The bench changes every control input only on the falling edge of the clock of the port it belongs to. Before it issues a read, it waits several reader-side cycles, so that the write toggle has crossed the synchronizer. It samples outputs on falling edges, or one nanosecond after a change when it tests the combinational enables.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned BUS_W = 36;
  localparam int unsigned SYNC_STAGES = 2;

  typedef struct packed {
    logic drive;   // bus output enable
    logic fifo;    // qualified FIFO strobe
    logic mb_wr;   // mailbox write
    logic mb_rd;   // mailbox read
  } port_ctl_t;
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[i] <= 1'b0;
      else if (i == 0) stage_q[i] <= d_i;
      else stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter bit IN_LEVEL      = 1'b1,  // direction level that selects input
  parameter bit FIFO_ON_INPUT = 1'b1   // FIFO strobe on input (write) or output (read)
) (
  input  logic      csn_i,
  input  logic      dir_i,
  input  logic      en_i,
  input  logic      mbx_i,
  output port_ctl_t ctl_o
);
  logic sel_in, sel_out, fifo_dir;

  assign sel_in  = !csn_i && (dir_i == IN_LEVEL);
  assign sel_out = !csn_i && (dir_i != IN_LEVEL);

  if (FIFO_ON_INPUT) begin : g_fifo_in
    assign fifo_dir = sel_in;
  end else begin : g_fifo_out
    assign fifo_dir = sel_out;
  end

  always_comb begin
    ctl_o.drive = sel_out;
    ctl_o.fifo  = en_i && !mbx_i && fifo_dir;
    ctl_o.mb_wr = en_i && mbx_i && sel_in;
    ctl_o.mb_rd = en_i && mbx_i && sel_out;
  end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel #(
  parameter int unsigned DW     = 36,
  parameter int unsigned STAGES = 2
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic          full_no
);
  logic          wr_tog_q, rd_tog_q;
  logic          wr_tog_r, rd_tog_w;
  logic [DW-1:0] data_q;
  logic          full_w, pending_r;

  // writer domain: full while write toggle is ahead of the returned read toggle
  assign full_w = wr_tog_q ^ rd_tog_w;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_tog_q <= 1'b0;
      data_q   <= '0;
    end else if (wr_i && !full_w) begin
      wr_tog_q <= ~wr_tog_q;
      data_q   <= wdata_i;
    end
  end

  mbx_sync #(.STAGES(STAGES)) u_w2r (
    .clk_i (rclk_i), .rst_ni(rst_ni), .d_i(wr_tog_q), .q_o(wr_tog_r)
  );
  mbx_sync #(.STAGES(STAGES)) u_r2w (
    .clk_i (wclk_i), .rst_ni(rst_ni), .d_i(rd_tog_q), .q_o(rd_tog_w)
  );

  // reader domain: only acknowledge a word that has arrived
  assign pending_r = wr_tog_r ^ rd_tog_q;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) rd_tog_q <= 1'b0;
    else if (rd_i && pending_r) rd_tog_q <= ~rd_tog_q;
  end

  // data_q is frozen while full, so the reader sees a stable word
  assign rdata_o = data_q;
  assign full_no = ~full_w;
endmodule

// File: rtl/mbx_port_ctrl.sv
module mbx_port_ctrl
  import mbx_pkg::*;
#(
  parameter int unsigned DW     = BUS_W,
  parameter int unsigned STAGES = SYNC_STAGES
) (
  input  logic          clk_a_i,
  input  logic          clk_b_i,
  input  logic          rst_ni,
  input  logic          a_csn_i,
  input  logic          a_dir_i,
  input  logic          a_en_i,
  input  logic          a_mbx_i,
  input  logic [DW-1:0] a_data_i,
  output logic [DW-1:0] a_data_o,
  output logic          a_oe_o,
  input  logic          b_csn_i,
  input  logic          b_dir_i,
  input  logic          b_en_i,
  input  logic          b_mbx_i,
  input  logic [DW-1:0] b_data_i,
  output logic [DW-1:0] b_data_o,
  output logic          b_oe_o,
  output logic          fifo_wr_o,
  output logic [DW-1:0] fifo_wdata_o,
  output logic          fifo_rd_o,
  input  logic [DW-1:0] fifo_rdata_i,
  output logic          mbf1_no,
  output logic          mbf2_no
);
  port_ctl_t     ctl_a, ctl_b;
  logic [DW-1:0] mb1_data, mb2_data;

  mbx_port_decode #(.IN_LEVEL(1'b1), .FIFO_ON_INPUT(1'b1)) u_dec_a (
    .csn_i(a_csn_i), .dir_i(a_dir_i), .en_i(a_en_i), .mbx_i(a_mbx_i), .ctl_o(ctl_a)
  );
  mbx_port_decode #(.IN_LEVEL(1'b0), .FIFO_ON_INPUT(1'b0)) u_dec_b (
    .csn_i(b_csn_i), .dir_i(b_dir_i), .en_i(b_en_i), .mbx_i(b_mbx_i), .ctl_o(ctl_b)
  );

  // mailbox 1: A -> B
  mbx_channel #(.DW(DW), .STAGES(STAGES)) u_mb1 (
    .wclk_i (clk_a_i), .rclk_i(clk_b_i), .rst_ni(rst_ni),
    .wr_i   (ctl_a.mb_wr), .wdata_i(a_data_i),
    .rd_i   (ctl_b.mb_rd), .rdata_o(mb1_data), .full_no(mbf1_no)
  );
  // mailbox 2: B -> A
  mbx_channel #(.DW(DW), .STAGES(STAGES)) u_mb2 (
    .wclk_i (clk_b_i), .rclk_i(clk_a_i), .rst_ni(rst_ni),
    .wr_i   (ctl_b.mb_wr), .wdata_i(b_data_i),
    .rd_i   (ctl_a.mb_rd), .rdata_o(mb2_data), .full_no(mbf2_no)
  );

  assign a_oe_o       = ctl_a.drive;
  assign b_oe_o       = ctl_b.drive;
  assign a_data_o     = mb2_data;
  assign b_data_o     = b_mbx_i ? mb1_data : fifo_rdata_i;
  assign fifo_wr_o    = ctl_a.fifo;
  assign fifo_rd_o    = ctl_b.fifo;
  assign fifo_wdata_o = a_data_i;
endmodule

module mbx_port_ctrl_chk (
  input logic clk_a_i,
  input logic clk_b_i,
  input logic rst_ni,
  input logic a_csn_i,
  input logic a_dir_i,
  input logic a_en_i,
  input logic a_mbx_i,
  input logic a_oe_o,
  input logic b_csn_i,
  input logic b_dir_i,
  input logic b_en_i,
  input logic b_mbx_i,
  input logic b_oe_o,
  input logic fifo_wr_o,
  input logic fifo_rd_o,
  input logic mbf1_no,
  input logic mbf2_no
);
  p_hiz_a_r1: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    a_csn_i |-> !a_oe_o && !fifo_wr_o);
  p_hiz_b_r1: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    b_csn_i |-> !b_oe_o && !fifo_rd_o);
  p_fifo_rd_r4: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    fifo_rd_o |-> b_oe_o && b_en_i && !b_mbx_i);
  p_en_low_r8: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!a_en_i && mbf1_no) |=> mbf1_no);
  p_mbf1_set_r5: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (!a_csn_i && a_dir_i && a_en_i && a_mbx_i && mbf1_no) |=> !mbf1_no);
  p_mbf2_set_r7: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (!b_csn_i && !b_dir_i && b_en_i && b_mbx_i && mbf2_no) |=> !mbf2_no);

  always @(posedge clk_a_i) begin
    if (!rst_ni) begin
      p_reset_r10: assert (mbf1_no && mbf2_no);
    end
  end
endmodule

bind mbx_port_ctrl mbx_port_ctrl_chk u_chk (.*);

// File: tb/mbx_port_ctrl_tb.sv
module mbx_port_ctrl_tb;
  localparam int DW = 36;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic a_csn = 1'b1, a_dir = 1'b0, a_en = 1'b0, a_mbx = 1'b0;
  logic b_csn = 1'b1, b_dir = 1'b0, b_en = 1'b0, b_mbx = 1'b0;
  logic [DW-1:0] a_din = '0, b_din = '0, f_rdata = '0;
  logic [DW-1:0] a_dout, b_dout, f_wdata;
  logic a_oe, b_oe, f_wr, f_rd, mbf1_n, mbf2_n;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk_a = ~clk_a;   // 200 MHz
  always #3.5 clk_b = ~clk_b;   // unrelated port B clock

  mbx_port_ctrl u_dut (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .a_csn_i(a_csn), .a_dir_i(a_dir), .a_en_i(a_en), .a_mbx_i(a_mbx),
    .a_data_i(a_din), .a_data_o(a_dout), .a_oe_o(a_oe),
    .b_csn_i(b_csn), .b_dir_i(b_dir), .b_en_i(b_en), .b_mbx_i(b_mbx),
    .b_data_i(b_din), .b_data_o(b_dout), .b_oe_o(b_oe),
    .fifo_wr_o(f_wr), .fifo_wdata_o(f_wdata), .fifo_rd_o(f_rd),
    .fifo_rdata_i(f_rdata), .mbf1_no(mbf1_n), .mbf2_no(mbf2_n)
  );

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_a(input logic csn, dir, en, mbx, input logic [DW-1:0] d);
    @(negedge clk_a);
    a_csn = csn; a_dir = dir; a_en = en; a_mbx = mbx; a_din = d;
  endtask

  task automatic set_b(input logic csn, dir, en, mbx, input logic [DW-1:0] d);
    @(negedge clk_b);
    b_csn = csn; b_dir = dir; b_en = en; b_mbx = mbx; b_din = d;
  endtask

  task automatic t_reset;
    chk(mbf1_n === 1'b1, "R10 mbf1", {35'd0, mbf1_n}, 36'd1);
    chk(mbf2_n === 1'b1, "R10 mbf2", {35'd0, mbf2_n}, 36'd1);
    chk(!a_oe && !b_oe, "R1 oe at reset", {34'd0, a_oe, b_oe}, 36'd0);
    chk(!f_wr && !f_rd, "R1 strobes at reset", {34'd0, f_wr, f_rd}, 36'd0);
  endtask

  task automatic t_direction;
    set_a(1'b0, 1'b0, 1'b0, 1'b0, '0); #1;
    chk(a_oe === 1'b1, "R2 A dir0 drives", {35'd0, a_oe}, 36'd1);
    a_dir = 1'b1; #1;
    chk(a_oe === 1'b0, "R11 A dir1 input no clock", {35'd0, a_oe}, 36'd0);
    a_dir = 1'b0; a_csn = 1'b1; #1;
    chk(a_oe === 1'b0, "R1 A csn high", {35'd0, a_oe}, 36'd0);
    set_b(1'b0, 1'b1, 1'b0, 1'b0, '0); #1;
    chk(b_oe === 1'b1, "R2 B dir1 drives", {35'd0, b_oe}, 36'd1);
    b_dir = 1'b0; #1;
    chk(b_oe === 1'b0, "R11 B dir0 input no clock", {35'd0, b_oe}, 36'd0);
    b_csn = 1'b1; #1;
    chk(b_oe === 1'b0, "R1 B csn high", {35'd0, b_oe}, 36'd0);
  endtask

  task automatic t_fifo;
    set_a(1'b0, 1'b1, 1'b1, 1'b0, 36'h123456789); #1;
    chk(f_wr === 1'b1, "R3 fifo_wr", {35'd0, f_wr}, 36'd1);
    chk(f_wdata === 36'h123456789, "R3 wdata", f_wdata, 36'h123456789);
    a_mbx = 1'b1; #1;
    chk(f_wr === 1'b0, "R3 mbx blocks fifo_wr", {35'd0, f_wr}, 36'd0);
    a_mbx = 1'b0; a_dir = 1'b0; #1;
    chk(f_wr === 1'b0, "R3 output dir no fifo_wr", {35'd0, f_wr}, 36'd0);
    a_dir = 1'b1; a_csn = 1'b1; #1;
    chk(f_wr === 1'b0, "R1 csn high no fifo_wr", {35'd0, f_wr}, 36'd0);
    a_csn = 1'b0; a_en = 1'b0; #1;
    chk(f_wr === 1'b0, "R8 en low no fifo_wr", {35'd0, f_wr}, 36'd0);
    set_a(1'b1, 1'b0, 1'b0, 1'b0, '0);
    f_rdata = 36'hABCDEF012;
    set_b(1'b0, 1'b1, 1'b1, 1'b0, '0); #1;
    chk(f_rd === 1'b1, "R4 fifo_rd", {35'd0, f_rd}, 36'd1);
    chk(b_dout === 36'hABCDEF012, "R4 b_data fifo", b_dout, 36'hABCDEF012);
    b_dir = 1'b0; #1;
    chk(f_rd === 1'b0, "R4 input dir no fifo_rd", {35'd0, f_rd}, 36'd0);
    b_dir = 1'b1; b_en = 1'b0; #1;
    chk(f_rd === 1'b0, "R8 en low no fifo_rd", {35'd0, f_rd}, 36'd0);
    set_b(1'b1, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic t_mbox1;
    bit seen;
    // read of empty mailbox 1 must not pre-acknowledge a later word
    set_b(1'b0, 1'b1, 1'b1, 1'b1, '0);
    set_b(1'b1, 1'b0, 1'b0, 1'b0, '0);
    set_a(1'b0, 1'b1, 1'b1, 1'b1, 36'h0000D1D1D);
    set_a(1'b0, 1'b1, 1'b1, 1'b1, 36'h00000E2E2); // attempt while full
    chk(mbf1_n === 1'b0, "R5 mbf1 low after write", {35'd0, mbf1_n}, 36'd0);
    set_a(1'b0, 1'b1, 1'b0, 1'b1, 36'h000003F3F); // en low
    chk(f_wr === 1'b0, "R8 en low mailbox no strobe", {35'd0, f_wr}, 36'd0);
    set_a(1'b1, 1'b0, 1'b0, 1'b0, '0);
    repeat (8) @(negedge clk_a);
    chk(mbf1_n === 1'b0, "R6 empty read ignored, still full", {35'd0, mbf1_n}, 36'd0);
    set_b(1'b0, 1'b1, 1'b0, 1'b1, '0); #1;
    chk(b_dout === 36'h0000D1D1D, "R9 full write ignored, R8 en low", b_dout, 36'h0000D1D1D);
    chk(b_oe === 1'b1, "R5 B drives mailbox", {35'd0, b_oe}, 36'd1);
    set_b(1'b0, 1'b1, 1'b1, 1'b1, '0);
    set_b(1'b1, 1'b0, 1'b0, 1'b0, '0);
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_a);
      if (mbf1_n === 1'b1) seen = 1'b1;
    end
    chk(seen, "R6 mbf1 returns high", {35'd0, mbf1_n}, 36'd1);
    set_a(1'b0, 1'b1, 1'b1, 1'b1, 36'h000004A4A);
    set_a(1'b1, 1'b0, 1'b0, 1'b0, '0);
    chk(mbf1_n === 1'b0, "R5 second write", {35'd0, mbf1_n}, 36'd0);
    repeat (5) @(negedge clk_b);
    b_csn = 1'b0; b_dir = 1'b1; b_mbx = 1'b1; #1;
    chk(b_dout === 36'h000004A4A, "R5 new word", b_dout, 36'h000004A4A);
    set_b(1'b0, 1'b1, 1'b1, 1'b1, '0);
    set_b(1'b1, 1'b0, 1'b0, 1'b0, '0);
    repeat (8) @(negedge clk_a);
    chk(mbf1_n === 1'b1, "R6 second read clears", {35'd0, mbf1_n}, 36'd1);
  endtask

  task automatic t_mbox2;
    bit seen;
    set_b(1'b0, 1'b0, 1'b1, 1'b1, 36'h00000B0B0);
    set_b(1'b1, 1'b0, 1'b0, 1'b0, '0);
    chk(mbf2_n === 1'b0, "R7 mbf2 low after write", {35'd0, mbf2_n}, 36'd0);
    repeat (5) @(negedge clk_a);
    a_csn = 1'b0; a_dir = 1'b0; a_mbx = 1'b1; #1;
    chk(a_dout === 36'h00000B0B0, "R7 a_data mailbox2", a_dout, 36'h00000B0B0);
    chk(a_oe === 1'b1, "R7 A drives", {35'd0, a_oe}, 36'd1);
    set_a(1'b0, 1'b0, 1'b1, 1'b1, '0);
    set_a(1'b1, 1'b0, 1'b0, 1'b0, '0);
    seen = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_b);
      if (mbf2_n === 1'b1) seen = 1'b1;
    end
    chk(seen, "R7 mbf2 returns high", {35'd0, mbf2_n}, 36'd1);
  endtask

  initial begin
    #1;
    t_reset;
    #20 rst_n = 1'b1;
    t_direction;
    t_fifo;
    t_mbox1;
    t_mbox2;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule